// File: doc/BRIEF.md
# I2C SCL Prescaled Clock Generator

This block produces the serial clock waveform of an I2C master from a fast functional clock. It works in two stages. A programmable divider first reduces the functional clock to an internal sampling tick. Two phase counters then count those ticks to set how long SCL stays low and how long it stays high. Each phase carries a fixed extra count in hardware: seven ticks for the low phase and five for the high phase. One SCL bit therefore spans `(psc+1) * (lo + 7 + hi + 5)` functional clock cycles.

Each of the two timing inputs is 16 bits wide. The lower byte holds the standard/fast-mode count and the upper byte holds the high-speed-mode count. The high-speed select input decides which byte is used. The divider value, both timing words and the mode select are captured together at the start of every SCL period. A change made partway through a period therefore never alters the phase that is running.

The outputs are the SCL level, the sampling tick, and a one-cycle strobe at the start of each phase. A bit-level sequencer uses the strobes to place data changes and sampling points. All control pins are plain level signals, and no stream data passes through the block.

Top module: `scl_pacer`

## Requirements
- R1: While `en` is low, `scl_o` is 1 from the next clock edge on, and `tick_o`, `lo_start_o` and `hi_start_o` stay 0.
- R2: While running, `tick_o` pulses for one cycle every `psc_val + 1` functional clock cycles.
- R3: With `hs_sel` = 0, the low phase lasts `(psc_val + 1) * (tlo_val[7:0] + 7)` cycles.
- R4: With `hs_sel` = 0, the high phase lasts `(psc_val + 1) * (thi_val[7:0] + 5)` cycles.
- R5: With `hs_sel` = 1, the counts come from `tlo_val[15:8]` and `thi_val[15:8]` in place of bits [7:0], and the same fixed additions of 7 and 5 apply.
- R6: The values of `psc_val`, `tlo_val`, `thi_val` and `hs_sel` are captured only on the clock edge that starts a low phase. Changes made at any other time act first in the following SCL period.
- R7: `lo_start_o` is high for exactly one cycle: the first cycle in which `scl_o` is 0. `hi_start_o` is high for exactly one cycle: the first cycle in which `scl_o` is 1 after a low phase.
- R8: After `en` rises, the first clock edge that samples it high starts a low phase. `scl_o` falls and `lo_start_o` pulses in that cycle. A run that restarts after `en` was dropped begins with a full-length low phase.
- R9: The timing byte of the mode not selected has no effect on the phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds SCL high and clears all counters |
| psc_val | input | 8 | Divider value; tick every psc_val+1 cycles |
| tlo_val | input | 16 | Low-phase counts: [7:0] standard/fast, [15:8] high-speed |
| thi_val | input | 16 | High-phase counts: [7:0] standard/fast, [15:8] high-speed |
| hs_sel | input | 1 | 1 selects the high-speed counts |
| scl_o | output | 1 | SCL level |
| tick_o | output | 1 | Sampling-tick strobe |
| lo_start_o | output | 1 | One-cycle strobe in the first cycle of a low phase |
| hi_start_o | output | 1 | One-cycle strobe in the first cycle of a high phase |

## Verification
The hardest case to reach from the ports is a configuration change while a period is in flight. The old values must stay in force for both remaining phases, and the new values must take over exactly at the next low-phase start. The stimulus waits for a low-phase strobe and then rewrites the divider and both timing words. It then measures the current low phase, the current high phase and the following low phase separately, with each length known in advance. A second sequence drops the enable in the middle of a low phase and raises it again, to check that the restart begins a full, fresh low phase.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_cfg_snap.sv
module scl_cfg_snap #(
  parameter int PSC_W  = 8,
  parameter int TIME_W = 8,
  parameter int LO_ADD = 7,
  parameter int HI_ADD = 5,
  localparam int LEN_W = TIME_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [PSC_W-1:0]    psc_in,
  input  logic [2*TIME_W-1:0] tlo_in,
  input  logic [2*TIME_W-1:0] thi_in,
  input  logic                hs_in,
  output logic [PSC_W-1:0]    psc_q,
  output logic [LEN_W-1:0]    lo_len,
  output logic [LEN_W-1:0]    hi_len
);
  logic [TIME_W-1:0] lo_pick, hi_pick;

  // choose the byte of the active speed mode
  assign lo_pick = hs_in ? tlo_in[2*TIME_W-1:TIME_W] : tlo_in[TIME_W-1:0];
  assign hi_pick = hs_in ? thi_in[2*TIME_W-1:TIME_W] : thi_in[TIME_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      lo_len <= LEN_W'(LO_ADD);
      hi_len <= LEN_W'(HI_ADD);
    end else if (load) begin
      psc_q  <= psc_in;
      lo_len <= {1'b0, lo_pick} + LEN_W'(LO_ADD);
      hi_len <= {1'b0, hi_pick} + LEN_W'(HI_ADD);
    end
  end
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] pc;

  assign tick = run && (pc == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (!run)   pc <= '0;
    else if (tick)   pc <= '0;
    else             pc <= pc + PSC_W'(1);
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= psc); // R2
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc == '0); // R1
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_pacer_pkg::*;
#(
  parameter int TIME_W = 8,
  localparam int LEN_W = TIME_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [LEN_W-1:0] hi_len,
  output logic             running,
  output logic             load,
  output logic             scl,
  output logic             lo_start,
  output logic             hi_start
);
  phase_e           state, state_n;
  logic [LEN_W-1:0] cnt, cnt_n;
  logic             to_high;

  assign running = (state != PH_IDLE);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    load    = 1'b0;
    to_high = 1'b0;
    unique case (state)
      PH_IDLE: begin
        cnt_n = '0;
        if (en) begin
          state_n = PH_LOW;
          load    = 1'b1;
        end
      end
      PH_LOW: begin
        if (!en) begin
          state_n = PH_IDLE;
          cnt_n   = '0;
        end else if (tick) begin
          if (cnt == lo_len - LEN_W'(1)) begin
            state_n = PH_HIGH;
            cnt_n   = '0;
            to_high = 1'b1;
          end else begin
            cnt_n = cnt + LEN_W'(1);
          end
        end
      end
      PH_HIGH: begin
        if (!en) begin
          state_n = PH_IDLE;
          cnt_n   = '0;
        end else if (tick) begin
          if (cnt == hi_len - LEN_W'(1)) begin
            state_n = PH_LOW;
            cnt_n   = '0;
            load    = 1'b1;
          end else begin
            cnt_n = cnt + LEN_W'(1);
          end
        end
      end
      default: begin
        state_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      scl      <= 1'b1;
      lo_start <= 1'b0;
      hi_start <= 1'b0;
    end else begin
      state    <= state_n;
      cnt      <= cnt_n;
      scl      <= (state_n != PH_LOW);
      lo_start <= load;
      hi_start <= to_high;
    end
  end

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW) |-> (cnt < lo_len)); // R3
  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HIGH) |-> (cnt < hi_len)); // R4
  AST_LO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    lo_start |-> $fell(scl)); // R7
  AST_HI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_start |-> $rose(scl)); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !lo_start && !hi_start)); // R1
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_start |=> !lo_start); // R7
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int PSC_W  = 8,
  parameter int TIME_W = 8,
  parameter int LO_ADD = 7,
  parameter int HI_ADD = 5,
  localparam int LEN_W = TIME_W + 1,
  localparam int REG_W = 2 * TIME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [REG_W-1:0] tlo_val,
  input  logic [REG_W-1:0] thi_val,
  input  logic             hs_sel,
  output logic             scl_o,
  output logic             tick_o,
  output logic             lo_start_o,
  output logic             hi_start_o
);
  logic [PSC_W-1:0] psc_q;
  logic [LEN_W-1:0] lo_len, hi_len;
  logic             running, load;

  scl_cfg_snap #(
    .PSC_W(PSC_W), .TIME_W(TIME_W), .LO_ADD(LO_ADD), .HI_ADD(HI_ADD)
  ) u_snap (
    .clk(clk), .rst_n(rst_n), .load(load),
    .psc_in(psc_val), .tlo_in(tlo_val), .thi_in(thi_val), .hs_in(hs_sel),
    .psc_q(psc_q), .lo_len(lo_len), .hi_len(hi_len)
  );

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .psc(psc_q), .tick(tick_o)
  );

  scl_phase_fsm #(.TIME_W(TIME_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick_o),
    .lo_len(lo_len), .hi_len(hi_len),
    .running(running), .load(load), .scl(scl_o),
    .lo_start(lo_start_o), .hi_start(hi_start_o)
  );

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> ($stable(lo_len) && $stable(hi_len) && $stable(psc_q))); // R6
  AST_TICK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> running); // R1
endmodule

// File: tb/scl_pacer_tb.sv
module scl_pacer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  psc_val = '0;
  logic [15:0] tlo_val = '0;
  logic [15:0] thi_val = '0;
  logic        hs_sel = 1'b0;
  logic        scl_o, tick_o, lo_start_o, hi_start_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scl_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .psc_val(psc_val),
    .tlo_val(tlo_val), .thi_val(thi_val), .hs_sel(hs_sel),
    .scl_o(scl_o), .tick_o(tick_o), .lo_start_o(lo_start_o), .hi_start_o(hi_start_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] p, input logic [15:0] lo,
                         input logic [15:0] hi, input logic hs);
    psc_val = p; tlo_val = lo; thi_val = hi; hs_sel = hs;
  endtask

  // raise enable; expects low-phase start at the next negedge (R8)
  task automatic start_run();
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R8 lo_start after enable", lo_start_o, 1);
    check("R8 scl low after enable", scl_o, 0);
  endtask

  // called right after lo_start seen; measures low phase length
  task automatic meas_low(output int n);
    int bad = 0;
    n = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (hi_start_o) break;
      if (scl_o !== 1'b0 || lo_start_o) bad++;
      n++;
    end
    check("R7 scl low and single lo_start in low phase", bad, 0);
    check("R7 scl high with hi_start", scl_o, 1);
  endtask

  // called right after hi_start seen; measures high phase length
  task automatic meas_high(output int n);
    int bad = 0;
    n = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (lo_start_o) break;
      if (scl_o !== 1'b1 || hi_start_o) bad++;
      n++;
    end
    check("R7 scl high and single hi_start in high phase", bad, 0);
    check("R7 scl low with lo_start", scl_o, 0);
  endtask

  task automatic meas_tick(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tick_o) break;
    end
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (tick_o) break;
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (scl_o !== 1'b1 || tick_o || lo_start_o || hi_start_o) bad++;
    end
    check("R1 idle outputs after reset", bad, 0);
  endtask

  task automatic t_basic();
    int lo, hi, tk;
    set_cfg(8'd0, 16'h0000, 16'h0000, 1'b0);
    start_run();
    meas_low(lo);
    check("R3 low len psc0 lo0", lo, 7);
    meas_high(hi);
    check("R4 high len psc0 hi0", hi, 5);
    meas_tick(tk);
    check("R2 tick interval psc0", tk, 1);
    stop_run();
  endtask

  task automatic t_psc();
    int lo, hi, tk;
    set_cfg(8'd2, 16'hAA03, 16'h5501, 1'b0);
    start_run();
    meas_low(lo);
    check("R3 R9 low len psc2 lo3", lo, 30);
    meas_high(hi);
    check("R4 R9 high len psc2 hi1", hi, 18);
    meas_tick(tk);
    check("R2 tick interval psc2", tk, 3);
    stop_run();
  endtask

  task automatic t_hs();
    int lo, hi;
    set_cfg(8'd1, {8'd2, 8'd50}, {8'd1, 8'd60}, 1'b1);
    start_run();
    meas_low(lo);
    check("R5 R9 hs low len", lo, 18);
    meas_high(hi);
    check("R5 R9 hs high len", hi, 12);
    stop_run();
  endtask

  task automatic t_midchange();
    int lo, hi;
    set_cfg(8'd0, 16'h0004, 16'h0002, 1'b0);
    start_run();
    repeat (2) @(negedge clk);
    set_cfg(8'd1, 16'h0000, 16'h0000, 1'b0);
    meas_low(lo);
    check("R6 low keeps old cfg", lo, 11 - 2);
    meas_high(hi);
    check("R6 high keeps old cfg", hi, 7);
    meas_low(lo);
    check("R6 next low uses new cfg", lo, 14);
    meas_high(hi);
    check("R6 next high uses new cfg", hi, 10);
    stop_run();
  endtask

  task automatic t_disable();
    int lo, bad = 0;
    set_cfg(8'd3, 16'h0001, 16'h0001, 1'b0);
    start_run();
    repeat (5) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_o !== 1'b1 || tick_o || lo_start_o || hi_start_o) bad++;
    end
    check("R1 disabled mid-phase quiet", bad, 0);
    start_run();
    meas_low(lo);
    check("R8 restart full low phase", lo, 32);
    stop_run();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_psc();
    t_hs();
    t_midchange();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule